// File: doc/BRIEF.md
# Decimal 4221 Carry-Save Compressor

This block takes a fixed number of decimal operands and reduces them, without any carry propagation across digits, to two decimal vectors: a sum vector S and a carry vector H, whose combined value S + 2H equals the sum of all operands. Every digit of every vector uses the 4221 weighted code. In that code any 4-bit pattern is a legal digit from 0 to 9, so the bitwise binary carry-save step needs no decimal correction.

The reduction is a tree of decimal 3:2 cells. Each cell runs four binary full adders per digit. An intermediate cell feeds its carry vector through a doubler. The doubler rewrites each 4221 digit in the 5211 code and then shifts the whole vector left by one bit, which yields twice the value, still in 4221. The last cell hands its carry vector out undoubled, so the consumer sees the pair (S, H) and finishes with one decimal carry-propagate addition of S + 2H.

The outputs are registered once. The operand count is chosen at elaboration from a fixed list of supported values.

Top module: `dec4221_csa_tree`

## Requirements
- R1: While reset is asserted, and up to the first rising clock edge after its release, `sum_o` and `carry_o` are all zeros.
- R2: Operands applied before a rising clock edge are reflected in `sum_o`/`carry_o` right after that edge, a latency of exactly one clock.
- R3: Digit value is 4·b3 + 2·b2 + 2·b1 + b0. Digit i of a vector has weight 10^i. The value of `sum_o` plus twice the value of `carry_o` equals the sum of the values of all `NUM_OPS` operands.
- R4: Every 4-bit input pattern is accepted, including non-canonical forms of the same digit (for example 0110 and 1000 both mean 4, and 0010 and 0100 both mean 2), and the result still meets R3.
- R5: The block elaborates for operand counts 3, 4, 5, 8 and 9, and rejects any other count, or a digit count outside 1 to 16, at elaboration.
- R6: The outputs are `DIGITS`+1 digits wide. With every input digit at 1111 (value 9) the result still meets R3, and no doubler drops a bit out of its top digit.
- R7: All-zero operands give `sum_o` and `carry_o` that are all zero bits.
- R8: No state carries from one operation to the next. An all-zero operation directly after an all-nines operation gives all-zero outputs.
- R9: Operand k occupies `ops_i[k*4*DIGITS +: 4*DIGITS]`, least significant digit at the lowest nibble. A single nonzero operand in any slot is summed at its own weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ops_i | input | NUM_OPS*DIGITS*4 | Concatenated 4221 operands, operand 0 in the lowest bits |
| sum_o | output | (DIGITS+1)*4 | Registered 4221 sum vector S |
| carry_o | output | (DIGITS+1)*4 | Registered 4221 carry vector H, to be doubled by the consumer |

## Verification
A wrong bit inside the tree, such as a miswired full adder, a bad 5211 recoding entry or a shift link that skips a digit, alters the value of S + 2H. The change shows at the ports one clock after the operands that exercise it. Because the pair is compared as a value and not as bit patterns, any such error is caught on the first operation that excites it, whatever non-canonical forms the tree legitimately produces. A stale register or leftover state shows as nonzero bits on the all-zero operation that follows an all-nines one.

// File: rtl/dec4221_pkg.sv
package dec4221_pkg;

   localparam int MAX_DIG  = 18;
   localparam int MAX_BITS = MAX_DIG * 4;

   // Value (0..9) of one 4221-coded digit.
   function automatic logic [3:0] val_4221(input logic [3:0] d);
      logic [3:0] r;
      r = {d[3], 3'b000} >> 1;
      r = r + {2'b00, d[2], 1'b0} + {2'b00, d[1], 1'b0} + {3'b000, d[0]};
      return r;
   endfunction

   // 5211 code (weights 5,2,1,1) of a value 0..9.
   function automatic logic [3:0] to_5211(input logic [3:0] v);
      logic [3:0] c;
      case (v)
         4'd0:    c = 4'b0000;
         4'd1:    c = 4'b0001;
         4'd2:    c = 4'b0100;
         4'd3:    c = 4'b0101;
         4'd4:    c = 4'b0111;
         4'd5:    c = 4'b1000;
         4'd6:    c = 4'b1001;
         4'd7:    c = 4'b1100;
         4'd8:    c = 4'b1101;
         4'd9:    c = 4'b1111;
         default: c = 4'b0000;
      endcase
      return c;
   endfunction

   // Integer value of a 4221 vector, most significant digit at the top.
   function automatic longint unsigned vec_val(input logic [MAX_BITS-1:0] v);
      longint unsigned acc;
      acc = 64'd0;
      for (int i = MAX_DIG - 1; i >= 0; i--) begin
         acc = acc * 64'd10 + 64'(val_4221(v[i*4 +: 4]));
      end
      return acc;
   endfunction

   // Operand count entering reduction level lvl.
   function automatic int level_count(input int q, input int lvl);
      int n;
      n = q;
      for (int l = 0; l < lvl; l++) begin
         n = 2 * (n / 3) + (n % 3);
      end
      return n;
   endfunction

   // Number of doubling levels before the final 3:2 cell.
   function automatic int level_steps(input int q);
      int n;
      int s;
      n = q;
      s = 0;
      while (n > 3 && s < 16) begin
         n = 2 * (n / 3) + (n % 3);
         s++;
      end
      return s;
   endfunction

endpackage

// File: rtl/d4221_digit_fa.sv
module d4221_digit_fa (
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   input  logic [3:0] c_i,
   output logic [3:0] s_o,
   output logic [3:0] h_o
);
   // One binary full adder per bit weight of the digit.
   for (genvar k = 0; k < 4; k++) begin : g_bit
      assign s_o[k] = a_i[k] ^ b_i[k] ^ c_i[k];
      assign h_o[k] = (a_i[k] & b_i[k]) | (a_i[k] & c_i[k]) | (b_i[k] & c_i[k]);
   end
endmodule

// File: rtl/d4221_x2.sv
module d4221_x2 #(
   parameter int DIGITS = 9
) (
   input  logic [DIGITS*4-1:0] v_i,
   output logic [DIGITS*4-1:0] v_o,
   output logic                ovf_o
);
   logic [DIGITS:0] link;

   assign link[0] = 1'b0;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [3:0] c5211;
      assign c5211 = dec4221_pkg::to_5211(dec4221_pkg::val_4221(v_i[i*4 +: 4]));
      // Shifted weights 10,4,2,2: top bit leaves as weight 1 of the next digit.
      assign v_o[i*4 +: 4] = {c5211[2:0], link[i]};
      assign link[i+1]     = c5211[3];
   end

   assign ovf_o = link[DIGITS];
endmodule

// File: rtl/d4221_csa32.sv
module d4221_csa32 #(
   parameter int DIGITS       = 9,
   parameter bit DOUBLE_CARRY = 1'b1
) (
   input  logic [DIGITS*4-1:0] a_i,
   input  logic [DIGITS*4-1:0] b_i,
   input  logic [DIGITS*4-1:0] c_i,
   output logic [DIGITS*4-1:0] sum_o,
   output logic [DIGITS*4-1:0] carry_o,
   output logic                ovf_o
);
   localparam int VB = DIGITS * 4;

   logic [VB-1:0] h_raw;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      d4221_digit_fa u_fa (
         .a_i (a_i[i*4 +: 4]),
         .b_i (b_i[i*4 +: 4]),
         .c_i (c_i[i*4 +: 4]),
         .s_o (sum_o[i*4 +: 4]),
         .h_o (h_raw[i*4 +: 4])
      );
   end

   if (DOUBLE_CARRY) begin : g_dbl
      d4221_x2 #(.DIGITS(DIGITS)) u_x2 (
         .v_i   (h_raw),
         .v_o   (carry_o),
         .ovf_o (ovf_o)
      );
   end else begin : g_raw
      assign carry_o = h_raw;
      assign ovf_o   = 1'b0;
   end
endmodule

// File: rtl/dec4221_csa_tree.sv
module dec4221_csa_tree #(
   parameter int NUM_OPS = 9,
   parameter int DIGITS  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_OPS*DIGITS*4-1:0]   ops_i,
   output logic [(DIGITS+1)*4-1:0]       sum_o,
   output logic [(DIGITS+1)*4-1:0]       carry_o
);
   localparam int OUT_DIG = DIGITS + 1;
   localparam int VB      = OUT_DIG * 4;
   localparam int IN_B    = DIGITS * 4;
   localparam int LEVELS  = dec4221_pkg::level_steps(NUM_OPS);

   // R5
   if (!(NUM_OPS inside {3, 4, 5, 8, 9})) begin : g_bad_ops
      $error("dec4221_csa_tree: NUM_OPS must be 3, 4, 5, 8 or 9");
   end
   if (DIGITS < 1 || DIGITS > 16) begin : g_bad_dig
      $error("dec4221_csa_tree: DIGITS must lie in 1..16");
   end

   logic [VB-1:0]      lvl_v [LEVELS+1][NUM_OPS];
   logic [3*LEVELS:0]  ovf_bits;
   logic [VB-1:0]      sum_d;
   logic [VB-1:0]      carry_d;
   logic [VB-1:0]      sum_q;
   logic [VB-1:0]      carry_q;
   logic               primed_q;

   // Level 0: operands widened by one zero digit at the top.
   for (genvar k = 0; k < NUM_OPS; k++) begin : g_in
      assign lvl_v[0][k] = {4'b0000, ops_i[k*IN_B +: IN_B]};
   end

   // Intermediate levels: groups of three reduced to S and 2H, rest passed on.
   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int N_IN  = dec4221_pkg::level_count(NUM_OPS, l);
      localparam int GRP   = N_IN / 3;
      localparam int REM   = N_IN % 3;
      localparam int N_OUT = 2 * GRP + REM;

      for (genvar g = 0; g < 3; g++) begin : g_cell
         if (g < GRP) begin : g_on
            d4221_csa32 #(.DIGITS(OUT_DIG), .DOUBLE_CARRY(1'b1)) u_csa (
               .a_i     (lvl_v[l][3*g]),
               .b_i     (lvl_v[l][3*g+1]),
               .c_i     (lvl_v[l][3*g+2]),
               .sum_o   (lvl_v[l+1][2*g]),
               .carry_o (lvl_v[l+1][2*g+1]),
               .ovf_o   (ovf_bits[l*3+g])
            );
         end else begin : g_off
            assign ovf_bits[l*3+g] = 1'b0;
         end
      end

      for (genvar k = 0; k < NUM_OPS; k++) begin : g_fill
         if (k >= 2*GRP && k < N_OUT) begin : g_pass
            assign lvl_v[l+1][k] = lvl_v[l][3*GRP + (k - 2*GRP)];
         end else if (k >= N_OUT) begin : g_zero
            assign lvl_v[l+1][k] = '0;
         end
      end
   end

   // Final 3:2 cell: carry leaves undoubled.
   d4221_csa32 #(.DIGITS(OUT_DIG), .DOUBLE_CARRY(1'b0)) u_final (
      .a_i     (lvl_v[LEVELS][0]),
      .b_i     (lvl_v[LEVELS][1]),
      .c_i     (lvl_v[LEVELS][2]),
      .sum_o   (sum_d),
      .carry_o (carry_d),
      .ovf_o   (ovf_bits[3*LEVELS])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q    <= '0;
         carry_q  <= '0;
         primed_q <= 1'b0;
      end else begin
         sum_q    <= sum_d;
         carry_q  <= carry_d;
         primed_q <= 1'b1;
      end
   end

   assign sum_o   = sum_q;
   assign carry_o = carry_q;

   // ---------------- checks ----------------
   function automatic longint unsigned wide_val(input logic [VB-1:0] x);
      return dec4221_pkg::vec_val({{(dec4221_pkg::MAX_BITS-VB){1'b0}}, x});
   endfunction

   longint unsigned lvl_sum [LEVELS+1];
   longint unsigned out_val;

   always_comb begin
      for (int l = 0; l <= LEVELS; l++) begin
         lvl_sum[l] = 64'd0;
         for (int k = 0; k < NUM_OPS; k++) begin
            lvl_sum[l] = lvl_sum[l] + wide_val(lvl_v[l][k]);
         end
      end
      out_val = wide_val(sum_q) + 64'd2 * wide_val(carry_q);
   end

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |-> (sum_o == '0 && carry_o == '0));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ovf_bits) == 0);

   // R2 R3
   out_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> (out_val == $past(lvl_sum[0])));

   for (genvar l = 1; l <= LEVELS; l++) begin : g_lchk
      // R3
      level_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_sum[l] == lvl_sum[0]);
   end
endmodule

// File: tb/dec4221_csa_tree_tb_top.sv
`timescale 1ns/1ps
module dec4221_csa_tree_tb_top;
   localparam int TB_DIG = 6;
   localparam int OPB    = TB_DIG * 4;
   localparam int OUTB   = (TB_DIG + 1) * 4;
   localparam int NV     = 5;
   localparam int QS [NV] = '{3, 4, 5, 8, 9};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [9*OPB-1:0] stim = '0;
   logic [OUTB-1:0]  s_out [NV];
   logic [OUTB-1:0]  h_out [NV];

   int checks = 0;
   int errors = 0;
   longint unsigned expq [NV][$];
   string tagq [$];

   always #4 clk = ~clk;

   for (genvar j = 0; j < NV; j++) begin : g_dut
      localparam int QJ = QS[j];
      dec4221_csa_tree #(.NUM_OPS(QJ), .DIGITS(TB_DIG)) dut_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .ops_i   (stim[QJ*OPB-1:0]),
         .sum_o   (s_out[j]),
         .carry_o (h_out[j])
      );
   end

   function automatic longint unsigned dval(input logic [OUTB-1:0] v);
      longint unsigned acc = 0;
      for (int i = TB_DIG; i >= 0; i--) begin
         acc = acc * 10 + 4*v[i*4+3] + 2*v[i*4+2] + 2*v[i*4+1] + v[i*4];
      end
      return acc;
   endfunction

   task automatic chk(input bit ok, input string tag, input int q,
                      input longint unsigned got, input longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s Q=%0d actual=%0d expected=%0d", tag, q, got, exp);
      end
   endtask

   task automatic check_all();
      string t;
      if (tagq.size() == 0) return;
      t = tagq.pop_front();
      for (int j = 0; j < NV; j++) begin
         longint unsigned e = expq[j].pop_front();
         longint unsigned g = dval(s_out[j]) + 2 * dval(h_out[j]);
         chk(g == e, t, QS[j], g, e);
         if (t == "R7" || t == "R8") begin
            chk(s_out[j] == '0 && h_out[j] == '0, t, QS[j],
                longint'(s_out[j] != '0) + longint'(h_out[j] != '0), 0);
         end
      end
   endtask

   // mode: 0 random, 1 zeros, 2 nines, 3 non-canonical, 4 single slot
   task automatic step(input int mode, input string tag, input int cyc);
      @(negedge clk);
      check_all();
      for (int k = 0; k < 9; k++) begin
         for (int i = 0; i < TB_DIG; i++) begin
            logic [3:0] d;
            case (mode)
               0: d = 4'($urandom_range(15, 0));
               1: d = 4'b0000;
               2: d = 4'b1111;
               3: case ((k + i + cyc) % 4)
                     0: d = 4'b0110;
                     1: d = 4'b1000;
                     2: d = 4'b0010;
                     default: d = 4'b0100;
                  endcase
               default: d = (k == cyc % 9) ? 4'($urandom_range(15, 1)) : 4'b0000;
            endcase
            stim[k*OPB + i*4 +: 4] = d;
         end
      end
      for (int j = 0; j < NV; j++) begin
         longint unsigned e = 0;
         for (int k = 0; k < QS[j]; k++) begin
            logic [OUTB-1:0] opv = {4'b0000, stim[k*OPB +: OPB]};
            e += dval(opv);
         end
         expq[j].push_back(e);
      end
      tagq.push_back(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end

   initial begin
      for (int k = 0; k < 9*OPB; k++) stim[k] = 1'($urandom_range(1, 0));
      repeat (3) begin
         @(negedge clk);
         for (int j = 0; j < NV; j++) begin
            // R1 outputs held at zero during reset
            chk(s_out[j] == '0 && h_out[j] == '0, "R1", QS[j],
                dval(s_out[j]) + dval(h_out[j]), 0);
         end
      end
      rst_n = 1'b1;
      step(1, "R7", 0);
      step(2, "R5/R6", 0);
      step(1, "R8", 0);
      for (int c = 0; c < 150; c++) step(0, "R2/R3", c);
      for (int c = 0; c < 8; c++) step(3, "R4", c);
      for (int c = 0; c < 9; c++) step(4, "R9", c);
      step(2, "R5/R6", 0);
      step(1, "R8", 0);
      for (int c = 0; c < 20; c++) step(0, "R2/R3", c);
      step(1, "R7", 0);
      @(negedge clk);
      check_all();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule